// File: doc/BRIEF.md
# Four-Mode Serial Port

A serial port of the kind found in small 8-bit controllers. It is driven through three byte-wide registers: a control register, a data buffer and a power register whose top bit doubles the bit rate. A two-bit mode field picks one of four framings:

- a synchronous shifter, where `txd` carries the shift clock and `rxd` carries the data;
- an 8-bit asynchronous frame;
- a 9-bit asynchronous frame at a rate fixed by the system clock;
- a 9-bit asynchronous frame timed by an external timer-overflow tick.

A write to the data buffer starts a transmission. Reception runs when the receive-enable bit is set. Completion raises sticky transmit-done and receive-done flags, which stay set until software clears them, and the two flags are ORed onto `irq`.

In the asynchronous modes the receiver oversamples each bit 16 times and reads the line at mid-bit. A start bit that is not still low at mid-bit is dropped. A multiprocessor filter can discard frames: in the 9-bit modes it keeps only frames whose 9th bit is 1, and in the 8-bit mode it keeps only frames with a valid stop bit.

Top module: `sport_unit`

## Requirements
- R1: After reset, the control register (address 0) and the power register (address 2) read 0x00, `txd` is 1, `rxd_oe` is 0 and `irq` is 0.
- R2: The control register holds mode in bits 1:0. Mode 0 is the synchronous shifter. In mode 0 a write to the data buffer (address 1) shifts its 8 bits out on `rxd_out`, LSB first, with `rxd_oe` high. Each bit lasts 12 clocks, and `txd` is low for the first 6 clocks of each bit and high for the last 6.
- R3: Mode 0 reception runs while rx-enable (control bit 3) is 1 and rx-done (control bit 7) is 0. It produces 8 shift clocks on `txd` and samples `rxd_in` at each rising edge, LSB first. It then loads the data buffer, sets rx-done and stops.
- R4: Mode 1 sends a 0 start bit, 8 data bits LSB first and a 1 stop bit. Each bit lasts 32 `tmr_tick` pulses, or 16 when power-register bit 7 is 1.
- R5: In mode 2 each bit lasts 64 clocks, or 32 clocks when power-register bit 7 is 1.
- R6: In modes 2 and 3, control bit 4 is sent as a 9th bit between the data and the stop bit. Mode 3 uses the same timing as mode 1.
- R7: Tx-done (control bit 6) is set when the stop bit begins, or after the 8th bit in mode 0. It stays set until software writes it to 0.
- R8: An accepted asynchronous frame loads the data buffer and sets rx-done. Control bit 5 takes the stop bit in mode 1 and the 9th bit in modes 2 and 3.
- R9: With rx-enable at 0, incoming frames leave rx-done and the data buffer unchanged.
- R10: A low pulse on `rxd_in` that ends before mid-bit is dropped without setting any flag.
- R11: In modes 2 and 3 with the multiprocessor bit (control bit 2) set, a frame whose 9th bit is 0 is discarded, and one whose 9th bit is 1 is accepted.
- R12: In mode 1 with the multiprocessor bit set, a frame with a 0 stop bit is discarded.
- R13: `irq` is high exactly while tx-done or rx-done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 2 | Register select: 0 control, 1 data, 2 power |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| tmr_tick | input | 1 | Timer-overflow pulse used by modes 1 and 3 |
| rxd_in | input | 1 | Receive line, and shift data input in mode 0 |
| rxd_out | output | 1 | Shift data output in mode 0 |
| rxd_oe | output | 1 | Drive enable for `rxd_out` |
| txd | output | 1 | Transmit line, or shift clock in mode 0 |
| irq | output | 1 | Interrupt request |

## Verification
Transmission is tried in every mode and with both states of the doubling bit. Bytes with mixed bit patterns show up a wrong bit order, and the measured bit period exposes a wrong divider or a doubling bit that does nothing. Reception is driven with clean frames, a short glitch, frames sent while receive is disabled, and frames whose 9th or stop bit fails the multiprocessor filter. Together these separate a filter that discards frames from one that lets everything through, and an aborted start from a frame that is merely late.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    MODE_SHIFT     = 2'd0,
    MODE_UART8     = 2'd1,
    MODE_UART9_FIX = 2'd2,
    MODE_UART9_TMR = 2'd3
  } sport_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PWR  = 2'd2,
    SEL_NONE = 2'd3
  } sport_sel_e;

  typedef struct packed {
    logic        rx_done;
    logic        tx_done;
    logic        rx9;
    logic        tx9;
    logic        rx_en;
    logic        mp_en;
    sport_mode_e mode;
  } sport_ctrl_t;

  // Modes 2 and 3 carry a ninth payload bit.
  function automatic logic has_ninth(sport_mode_e m);
    return m[1];
  endfunction

  // Multiprocessor filter: ninth bit in 9-bit modes, stop bit in 8-bit mode.
  function automatic logic frame_accept(sport_mode_e m, logic mp, logic bit9, logic stopb);
    if (!mp) return 1'b1;
    return has_ninth(m) ? bit9 : stopb;
  endfunction
endpackage

// File: rtl/sport_baud.sv
module sport_baud import sport_pkg::*; #(
  parameter int OS          = 16,
  parameter int FIX_DIV     = 64,
  parameter int TMR_PER_BIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sport_mode_e mode,
  input  logic        dbl,
  input  logic        tmr_tick,
  output logic        os_tick
);
  localparam int FIX_OS = FIX_DIV / OS;
  localparam int TMR_OS = TMR_PER_BIT / OS;
  localparam int MAX_OS = (FIX_OS > TMR_OS) ? FIX_OS : TMR_OS;
  localparam int CW     = $clog2(MAX_OS) + 1;

  logic [CW-1:0] cnt, lim;
  logic          step, wrap;

  always_comb begin
    if (mode == MODE_UART9_FIX) begin
      step = 1'b1;
      lim  = dbl ? CW'(FIX_OS / 2 - 1) : CW'(FIX_OS - 1);
    end else begin
      step = tmr_tick;
      lim  = dbl ? CW'(TMR_OS / 2 - 1) : CW'(TMR_OS - 1);
    end
  end

  assign wrap    = (cnt >= lim);
  assign os_tick = step & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R5
  fix_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && mode == MODE_UART9_FIX) ##1 (mode == MODE_UART9_FIX) |-> !os_tick);
endmodule

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int DW  = 8,
  parameter int DIV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tx,
  input  logic          start_rx,
  input  logic [DW-1:0] tx_data,
  input  logic          rxd_in,
  output logic          busy,
  output logic          drv,
  output logic          sclk,
  output logic          dout,
  output logic          done_tx,
  output logic          done_rx,
  output logic [DW-1:0] rx_data
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int BW   = $clog2(DW);

  logic [CW-1:0] ph;
  logic [BW-1:0] idx;
  logic [DW-1:0] sh;
  logic          dir_rx;
  logic          last, final_bit;

  assign last      = busy && (ph == CW'(DIV - 1));
  assign final_bit = last && (idx == BW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_rx <= 1'b0; ph <= '0; idx <= '0; sh <= '0;
    end else if (!busy) begin
      if (start_tx) begin
        busy <= 1'b1; dir_rx <= 1'b0; ph <= '0; idx <= '0; sh <= tx_data;
      end else if (start_rx) begin
        busy <= 1'b1; dir_rx <= 1'b1; ph <= '0; idx <= '0;
      end
    end else begin
      ph <= last ? '0 : ph + 1'b1;
      if (dir_rx && ph == CW'(HALF - 1)) sh <= {rxd_in, sh[DW-1:1]};
      if (last) begin
        if (!dir_rx) sh <= {1'b0, sh[DW-1:1]};
        idx <= idx + 1'b1;
        if (final_bit) busy <= 1'b0;
      end
    end
  end

  assign drv     = busy && !dir_rx;
  assign sclk    = busy ? (ph >= CW'(HALF)) : 1'b1;
  assign dout    = drv ? sh[0] : 1'b1;
  assign done_tx = final_bit && !dir_rx;
  assign done_rx = final_bit && dir_rx;
  assign rx_data = sh;

  // R2
  shift_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv && ph != '0) |-> $stable(dout));
endmodule

// File: rtl/sport_atx.sv
module sport_atx #(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          start,
  input  logic          ninth_en,
  input  logic          ninth,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          line,
  output logic          stop_ev
);
  localparam int PW = $clog2(DW + 3);
  localparam int SW = $clog2(OS);

  logic [PW-1:0] pos, last_pos;
  logic [SW-1:0] sub;
  logic [DW:0]   sh;
  logic          n9, in_stop, bit_end;

  assign last_pos = n9 ? PW'(DW + 1) : PW'(DW);
  assign bit_end  = busy && os_tick && (sub == SW'(OS - 1));
  assign stop_ev  = bit_end && !in_stop && (pos == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; line <= 1'b1; pos <= '0; sub <= '0; sh <= '0; n9 <= 1'b0; in_stop <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; line <= 1'b0; pos <= '0; sub <= '0;
        sh <= {ninth, data}; n9 <= ninth_en; in_stop <= 1'b0;
      end
    end else if (os_tick) begin
      sub <= sub + 1'b1;
      if (bit_end) begin
        if (in_stop) begin
          busy <= 1'b0; line <= 1'b1;
        end else if (pos == last_pos) begin
          in_stop <= 1'b1; line <= 1'b1;
        end else begin
          pos <= pos + 1'b1; line <= sh[0]; sh <= sh >> 1;
        end
      end
    end
  end

  // R7
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> line);
endmodule

// File: rtl/sport_arx.sv
module sport_arx #(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          en,
  input  logic          ninth_en,
  input  logic          rxd_in,
  output logic          busy,
  output logic          done_ev,
  output logic          abort_ev,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          stop_o
);
  localparam int PW = $clog2(DW + 3);
  localparam int SW = $clog2(OS);

  logic          s1, s2, prev;
  logic [SW-1:0] sub;
  logic [PW-1:0] pos, last_pay;
  logic [DW:0]   sh;
  logic          mid;

  assign last_pay = ninth_en ? PW'(DW + 1) : PW'(DW);
  assign mid      = busy && os_tick && (sub == SW'(OS / 2 - 1));
  assign abort_ev = mid && (pos == '0) && s2;
  assign done_ev  = mid && (pos == last_pay + 1'b1);
  assign data_o   = ninth_en ? sh[DW-1:0] : sh[DW:1];
  assign bit9_o   = sh[DW];
  assign stop_o   = s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      busy <= 1'b0; sub <= '0; pos <= '0; sh <= '0;
    end else begin
      s1 <= rxd_in;
      s2 <= s1;
      if (os_tick) begin
        prev <= s2;
        if (!busy) begin
          if (en && prev && !s2) begin
            busy <= 1'b1; sub <= '0; pos <= '0;
          end
        end else begin
          sub <= sub + 1'b1;
          if (mid) begin
            if (pos == '0) begin
              if (s2) busy <= 1'b0;
              else    pos  <= pos + 1'b1;
            end else if (pos <= last_pay) begin
              sh  <= {s2, sh[DW:1]};
              pos <= pos + 1'b1;
            end else begin
              busy <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !busy);
endmodule

// File: rtl/sport_unit.sv
module sport_unit import sport_pkg::*; #(
  parameter int OS          = 16,
  parameter int SYNC_DIV    = 12,
  parameter int FIX_DIV     = 64,
  parameter int TMR_PER_BIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             tmr_tick,
  input  logic             rxd_in,
  output logic             rxd_out,
  output logic             rxd_oe,
  output logic             txd,
  output logic             irq
);
  sport_ctrl_t      ctrl_q;
  logic             dbl_q;
  logic [REG_W-1:0] rx_buf;
  sport_mode_e      mode;
  logic             ctrl_wr, data_wr, pwr_wr;
  logic             os_tick;
  logic             sy_busy, sy_drv, sy_clk, sy_dout, sy_done_tx, sy_done_rx;
  logic [REG_W-1:0] sy_rx;
  logic             at_busy, at_line, at_stop_ev;
  logic             ar_busy, ar_done, ar_abort, ar_bit9, ar_stop;
  logic [REG_W-1:0] ar_data;
  logic             ar_accept, tx_set, rx_acc;

  assign mode    = ctrl_q.mode;
  assign ctrl_wr = wr_en && (addr == SEL_CTRL);
  assign data_wr = wr_en && (addr == SEL_DATA);
  assign pwr_wr  = wr_en && (addr == SEL_PWR);

  sport_baud #(.OS(OS), .FIX_DIV(FIX_DIV), .TMR_PER_BIT(TMR_PER_BIT)) u_baud (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(dbl_q), .tmr_tick(tmr_tick), .os_tick(os_tick));

  sport_sync #(.DW(REG_W), .DIV(SYNC_DIV)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .start_tx(data_wr && mode == MODE_SHIFT),
    .start_rx(mode == MODE_SHIFT && ctrl_q.rx_en && !ctrl_q.rx_done),
    .tx_data(wr_data), .rxd_in(rxd_in),
    .busy(sy_busy), .drv(sy_drv), .sclk(sy_clk), .dout(sy_dout),
    .done_tx(sy_done_tx), .done_rx(sy_done_rx), .rx_data(sy_rx));

  sport_atx #(.DW(REG_W), .OS(OS)) u_atx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .start(data_wr && mode != MODE_SHIFT),
    .ninth_en(has_ninth(mode)), .ninth(ctrl_q.tx9), .data(wr_data),
    .busy(at_busy), .line(at_line), .stop_ev(at_stop_ev));

  sport_arx #(.DW(REG_W), .OS(OS)) u_arx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .en(ctrl_q.rx_en && mode != MODE_SHIFT), .ninth_en(has_ninth(mode)), .rxd_in(rxd_in),
    .busy(ar_busy), .done_ev(ar_done), .abort_ev(ar_abort),
    .data_o(ar_data), .bit9_o(ar_bit9), .stop_o(ar_stop));

  assign ar_accept = ar_done && frame_accept(mode, ctrl_q.mp_en, ar_bit9, ar_stop);
  assign tx_set    = sy_done_tx || at_stop_ev;
  assign rx_acc    = sy_done_rx || ar_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dbl_q  <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= sport_ctrl_t'(wr_data);
      if (pwr_wr)  dbl_q  <= wr_data[REG_W-1];
      if (tx_set)  ctrl_q.tx_done <= 1'b1;
      if (sy_done_rx) begin
        ctrl_q.rx_done <= 1'b1;
        rx_buf         <= sy_rx;
      end else if (ar_accept) begin
        ctrl_q.rx_done <= 1'b1;
        ctrl_q.rx9     <= has_ninth(mode) ? ar_bit9 : ar_stop;
        rx_buf         <= ar_data;
      end
    end
  end

  always_comb begin
    case (addr)
      SEL_CTRL: rd_data = ctrl_q;
      SEL_DATA: rd_data = rx_buf;
      SEL_PWR:  rd_data = {dbl_q, {(REG_W-1){1'b0}}};
      default:  rd_data = '0;
    endcase
  end

  assign txd     = (mode == MODE_SHIFT) ? sy_clk : at_line;
  assign rxd_out = sy_dout;
  assign rxd_oe  = (mode == MODE_SHIFT) && sy_drv;
  assign irq     = ctrl_q.tx_done || ctrl_q.rx_done;

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.tx_done) |-> $past(ctrl_wr));

  // R9
  rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_q.rx_done) && !$past(ctrl_wr)) |-> $past(ctrl_q.rx_en));

  // R11
  mp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_done && has_ninth(mode) && ctrl_q.mp_en && !ar_bit9) |=> $stable(rx_buf));
endmodule

// File: tb/sim_sport_unit.sv
module sim_sport_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       tmr_tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic       rxd_out, rxd_oe, txd, irq;
  int         checks = 0;
  int         errors = 0;

  sport_unit u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tmr_tick(tmr_tick), .rxd_in(rxd_in), .rxd_out(rxd_out),
    .rxd_oe(rxd_oe), .txd(txd), .irq(irq));

  always #5 clk = ~clk;

  // Timer overflow pulse every 3 clocks.
  initial begin
    forever begin
      repeat (2) @(negedge clk);
      tmr_tick = 1'b1;
      @(negedge clk);
      tmr_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  // Expected async frame measured at bit centres from the falling start edge.
  task automatic tx_check(input logic [7:0] d, input bit n9, input bit b9, input int per, input string tag);
    logic [10:0] bits;
    logic [7:0]  c;
    int          nb;
    nb   = n9 ? 11 : 10;
    bits = n9 ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    while (txd !== 1'b0) @(negedge clk);
    repeat (per / 2) @(negedge clk);
    chk({tag, " start"}, txd, bits[0]);
    for (int k = 1; k < nb; k++) begin
      repeat (per) @(negedge clk);
      chk($sformatf("%s bit%0d", tag, k), txd, bits[k]);
    end
    rd(2'd0, c);
    chk({tag, " R7 tx_done at stop"}, c[6], 1'b1);
    chk({tag, " R13 irq"}, irq, 1'b1);
    repeat (per) @(negedge clk);
    wr(2'd0, c & 8'h3F);
  endtask

  task automatic rx_send(input logic [7:0] d, input bit n9, input bit b9, input bit stopv, input int per);
    rxd_in = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_in = d[i];
      repeat (per) @(negedge clk);
    end
    if (n9) begin
      rxd_in = b9;
      repeat (per) @(negedge clk);
    end
    rxd_in = stopv;
    repeat (per) @(negedge clk);
    rxd_in = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 pwr", v, 8'h00);
    chk("R1 txd", txd, 1'b1);
    chk("R1 oe", rxd_oe, 1'b0);
    chk("R1 irq", irq, 1'b0);

    // R2 mode 0 transmit of 0xA5
    wr(2'd1, 8'hA5);
    for (int i = 0; i < 8; i++) begin
      repeat (2) @(negedge clk);
      chk($sformatf("R2 m0 clk low b%0d", i), txd, 1'b0);
      chk($sformatf("R2 m0 oe b%0d", i), rxd_oe, 1'b1);
      chk($sformatf("R2 m0 data b%0d", i), rxd_out, (8'hA5 >> i) & 1);
      repeat (6) @(negedge clk);
      chk($sformatf("R2 m0 clk high b%0d", i), txd, 1'b1);
      repeat (4) @(negedge clk);
    end
    rd(2'd0, v); chk("R7 m0 tx_done", v[6], 1'b1);
    chk("R13 irq tx", irq, 1'b1);
    chk("R2 oe idle", rxd_oe, 1'b0);
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R7 tx_done held", v[6], 1'b1);
    wr(2'd0, 8'h00);
    chk("R13 irq cleared", irq, 1'b0);

    // R3 mode 0 receive of 0x3C
    rxd_in = 1'b0;
    wr(2'd0, 8'h08);
    for (int i = 0; i < 8; i++) begin
      rxd_in = (8'h3C >> i) & 1;
      @(posedge txd);
      #1;
    end
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R3 rx_done", v[7], 1'b1);
    rd(2'd1, v); chk("R3 data", v, 8'h3C);
    repeat (20) @(negedge clk);
    chk("R3 stopped", txd, 1'b1);
    rxd_in = 1'b1;
    wr(2'd0, 8'h00);

    // R4 mode 1, both rates
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h4D); tx_check(8'h4D, 0, 0, 96, "R4 m1");
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h81); tx_check(8'h81, 0, 0, 48, "R4 m1 dbl");
    // R5 R6 mode 2
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h5A); tx_check(8'h5A, 1, 1, 64, "R5 R6 m2");
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'hF0); tx_check(8'hF0, 1, 0, 32, "R5 m2 dbl");
    // R6 mode 3
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h13);
    wr(2'd1, 8'h2B); tx_check(8'h2B, 1, 1, 96, "R6 m3");

    // R8 mode 1 receive
    wr(2'd0, 8'h09);
    rx_send(8'hC3, 0, 0, 1, 96);
    rd(2'd0, v); chk("R8 m1 rx_done", v[7], 1'b1); chk("R8 m1 stop bit", v[5], 1'b1);
    chk("R13 irq rx", irq, 1'b1);
    rd(2'd1, v); chk("R8 m1 data", v, 8'hC3);

    // R9 receive disabled
    wr(2'd0, 8'h01);
    rx_send(8'h11, 0, 0, 1, 96);
    rd(2'd0, v); chk("R9 no rx_done", v[7], 1'b0);
    rd(2'd1, v); chk("R9 buffer kept", v, 8'hC3);

    // R10 false start, then a good frame
    wr(2'd0, 8'h09);
    rxd_in = 1'b0;
    repeat (24) @(negedge clk);
    rxd_in = 1'b1;
    repeat (300) @(negedge clk);
    rd(2'd0, v); chk("R10 glitch dropped", v[7], 1'b0);
    rx_send(8'h66, 0, 0, 1, 96);
    rd(2'd1, v); chk("R10 next frame", v, 8'h66);

    // R12 mode 1 multiprocessor, bad stop
    wr(2'd0, 8'h0D);
    rx_send(8'h77, 0, 0, 0, 96);
    rd(2'd0, v); chk("R12 bad stop dropped", v[7], 1'b0);
    rd(2'd1, v); chk("R12 buffer kept", v, 8'h66);
    rx_send(8'h78, 0, 0, 1, 96);
    rd(2'd1, v); chk("R12 good stop data", v, 8'h78);

    // R11 mode 2 multiprocessor filter
    wr(2'd0, 8'h0E);
    rx_send(8'h99, 1, 0, 1, 64);
    rd(2'd0, v); chk("R11 ninth 0 dropped", v[7], 1'b0);
    rd(2'd1, v); chk("R11 buffer kept", v, 8'h78);
    rx_send(8'h9A, 1, 1, 1, 64);
    rd(2'd0, v); chk("R11 ninth 1 accepted", v[7], 1'b1); chk("R11 rx9", v[5], 1'b1);
    rd(2'd1, v); chk("R11 data", v, 8'h9A);

    // R8 mode 3 receive with doubling, ninth bit 0
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h2B);
    rx_send(8'h35, 1, 0, 1, 48);
    rd(2'd0, v); chk("R8 m3 rx_done", v[7], 1'b1); chk("R8 m3 ninth", v[5], 1'b0);
    rd(2'd1, v); chk("R8 m3 data", v, 8'h35);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule